// File: doc/BRIEF.md
# Audio Half-Word TDM Streamer

The streamer carries two-channel 16-bit audio between a word-wide sample store and a serial audio port that runs two TDM slots per frame. On the transmit side it takes 32-bit words, each holding a pair of samples, and sends them one sample per slot: the lower half first, then the upper half. It zeroes each word in the store as it takes it. On the receive side it trims every incoming port word to 16 bits and packs two of them into one 32-bit word. The first sample goes in the lower half.

The serial port is modelled at word level. A transmit slot-request strobe means the port can take a word. A receive-valid strobe means a word has arrived. A start pulse runs a short priming sequence before streaming begins. The sequence writes one zero word at once, writes a second zero word at the first transmit request, and throws away the first received word. This keeps the transmit slots and the receive slots aligned. A buffer-start pulse puts both half-word phases back to the lower half. A slot that finds no stored word gets a zero sample and sets a sticky underrun flag.

Top module: `tdm_audio_streamer`

## Requirements
- R1: While rst_ni is low, and after reset is released, ser_tx_we_o, src_pop_o, rx_word_valid_o and underrun_o are 0.
- R2: start_i is sampled at a rising edge. At the next rising edge the block writes a zero word to the port (ser_tx_we_o=1, ser_tx_data_o=0) without waiting for ser_tx_ready_i.
- R3: After the first zero word, the next ser_tx_ready_i is answered with a second zero word. For that request src_pop_o stays 0, even if src_valid_i is 1.
- R4: After the second zero word, the first ser_rx_valid_i word is discarded. It gives no rx_word_valid_o and does not fill either half.
- R5: While streaming, a ser_tx_ready_i in the low phase with src_valid_i=1 raises src_pop_o in that same cycle. This means read and zero the word. One edge later the port sees src_data_i[15:0], zero-extended.
- R6: The ser_tx_ready_i after a fetch sends bits [31:16] of the fetched word. It does not raise src_pop_o, and the phase returns to low.
- R7: While streaming, an even received word is trimmed to bits [15:0] and held. It gives no output.
- R8: An odd received word produces rx_word_valid_o one edge later, with rx_word_o = {odd[15:0], even[15:0]}.
- R9: A ser_tx_ready_i in the low phase with src_valid_i=0 sends a zero word and sets underrun_o. The phase stays low. underrun_o then stays 1 until the next start_i.
- R10: buf_start_i forces both the transmit phase and the receive phase to low. A port event in the same cycle is treated as low phase.
- R11: start_i clears underrun_o at the next edge and runs the priming sequence again from R2.
- R12: Before the first start_i, port events cause no port write, no fetch and no packed output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; runs the priming sequence |
| buf_start_i | input | 1 | Buffer boundary; both phases to low half |
| src_valid_i | input | 1 | Stored transmit word available |
| src_data_i | input | 32 | Stored transmit word, two samples |
| src_pop_o | output | 1 | Read-and-zero of the current stored word |
| ser_tx_ready_i | input | 1 | Port transmit slot request |
| ser_tx_we_o | output | 1 | Port transmit write |
| ser_tx_data_o | output | 32 | Port transmit word, sample zero-extended |
| ser_rx_valid_i | input | 1 | Port received word present |
| ser_rx_data_i | input | 32 | Port received word |
| rx_word_valid_o | output | 1 | Packed receive word strobe |
| rx_word_o | output | 32 | Packed receive word |
| underrun_o | output | 1 | Sticky transmit underrun flag |

## Verification
The hardest cases to reach are phase misalignment and its repair. The transmit or receive phase has to be left in the high half, and then a buffer boundary has to arrive in the same cycle as a port event. The stimulus gets there by leaving a transmit word half-sent and a receive pair half-filled. It then pulses buf_start_i together with the next slot request and with the next received word. It checks that a fresh word is fetched and that the packed word starts from the realigned sample. Underrun is reached by holding src_valid_i low for a low-phase slot. The test then shows that the phase did not advance and that the flag outlives later good slots.

// File: rtl/tdm_stream_pkg.sv
package tdm_stream_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRIME = 3'd1,
    ST_PAD   = 3'd2,
    ST_DROP  = 3'd3,
    ST_RUN   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/tdm_seq_ctrl.sv
module tdm_seq_ctrl
  import tdm_stream_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_slot_i,
  input  logic       rx_valid_i,
  output seq_state_e state_o,
  output logic       pad_we_o,
  output logic       run_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_IDLE;
      ST_PRIME: state_d = ST_PAD;
      ST_PAD:   if (tx_slot_i) state_d = ST_DROP;
      ST_DROP:  if (rx_valid_i) state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
    if (start_i) state_d = ST_PRIME;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // prime word needs no slot request; pad word waits for one
  assign pad_we_o = !start_i && ((state_q == ST_PRIME) || (state_q == ST_PAD && tx_slot_i));
  assign run_o    = !start_i && (state_q == ST_RUN);
  assign state_o  = state_q;
endmodule

// File: rtl/tdm_tx_unpack.sv
module tdm_tx_unpack #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned PORT_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  run_i,
  input  logic                  realign_i,
  input  logic                  slot_i,
  input  logic                  pad_we_i,
  input  logic                  src_valid_i,
  input  logic [2*SAMPLE_W-1:0] src_data_i,
  output logic                  src_pop_o,
  output logic                  ser_we_o,
  output logic [PORT_W-1:0]     ser_data_o,
  output logic                  underrun_o
);
  localparam int unsigned LANES = 2;

  logic [SAMPLE_W-1:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = src_data_i[g*SAMPLE_W +: SAMPLE_W];
  end

  logic                hi_q;
  logic [SAMPLE_W-1:0] hold_q;
  logic                we_q, urun_q;
  logic [PORT_W-1:0]   data_q;
  logic                phase_hi, even_ev, odd_ev;
  logic [SAMPLE_W-1:0] sample_d;

  assign phase_hi  = hi_q && !realign_i;
  assign even_ev   = run_i && slot_i && !phase_hi;
  assign odd_ev    = run_i && slot_i && phase_hi;
  assign src_pop_o = even_ev && src_valid_i;

  always_comb begin
    sample_d = '0;
    if (src_pop_o)   sample_d = lane[0];
    else if (odd_ev) sample_d = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      hold_q <= '0;
      we_q   <= 1'b0;
      data_q <= '0;
      urun_q <= 1'b0;
    end else begin
      we_q   <= pad_we_i || (run_i && slot_i);
      data_q <= PORT_W'(sample_d);
      if (!run_i)         hi_q <= 1'b0;
      else if (src_pop_o) hi_q <= 1'b1;
      else if (odd_ev)    hi_q <= 1'b0;
      else if (realign_i) hi_q <= 1'b0;
      if (src_pop_o) hold_q <= lane[1];
      if (clr_i)                          urun_q <= 1'b0;
      else if (even_ev && !src_valid_i)   urun_q <= 1'b1;
    end
  end

  assign ser_we_o   = we_q;
  assign ser_data_o = data_q;
  assign underrun_o = urun_q;
endmodule

// File: rtl/tdm_rx_pack.sv
module tdm_rx_pack #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned PORT_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  realign_i,
  input  logic                  rx_valid_i,
  input  logic [PORT_W-1:0]     rx_data_i,
  output logic                  word_valid_o,
  output logic [2*SAMPLE_W-1:0] word_o
);
  logic                  hi_q, valid_q, phase_hi, ev;
  logic [SAMPLE_W-1:0]   lo_q, trimmed;
  logic [2*SAMPLE_W-1:0] word_q;

  assign trimmed  = rx_data_i[SAMPLE_W-1:0];
  assign phase_hi = hi_q && !realign_i;
  assign ev       = run_i && rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= 1'b0;
      lo_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!run_i) begin
        hi_q <= 1'b0;
      end else if (ev && !phase_hi) begin
        lo_q <= trimmed;
        hi_q <= 1'b1;
      end else if (ev) begin
        word_q  <= {trimmed, lo_q};
        valid_q <= 1'b1;
        hi_q    <= 1'b0;
      end else if (realign_i) begin
        hi_q <= 1'b0;
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_o       = word_q;
endmodule

// File: rtl/tdm_audio_streamer.sv
module tdm_audio_streamer
  import tdm_stream_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned PORT_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  buf_start_i,
  input  logic                  src_valid_i,
  input  logic [2*SAMPLE_W-1:0] src_data_i,
  output logic                  src_pop_o,
  input  logic                  ser_tx_ready_i,
  output logic                  ser_tx_we_o,
  output logic [PORT_W-1:0]     ser_tx_data_o,
  input  logic                  ser_rx_valid_i,
  input  logic [PORT_W-1:0]     ser_rx_data_i,
  output logic                  rx_word_valid_o,
  output logic [2*SAMPLE_W-1:0] rx_word_o,
  output logic                  underrun_o
);
  seq_state_e seq_state;
  logic       pad_we, run;

  tdm_seq_ctrl u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tx_slot_i  (ser_tx_ready_i),
    .rx_valid_i (ser_rx_valid_i),
    .state_o    (seq_state),
    .pad_we_o   (pad_we),
    .run_o      (run)
  );

  tdm_tx_unpack #(.SAMPLE_W(SAMPLE_W), .PORT_W(PORT_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .run_i       (run),
    .realign_i   (buf_start_i),
    .slot_i      (ser_tx_ready_i),
    .pad_we_i    (pad_we),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_pop_o   (src_pop_o),
    .ser_we_o    (ser_tx_we_o),
    .ser_data_o  (ser_tx_data_o),
    .underrun_o  (underrun_o)
  );

  tdm_rx_pack #(.SAMPLE_W(SAMPLE_W), .PORT_W(PORT_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .realign_i    (buf_start_i),
    .rx_valid_i   (ser_rx_valid_i),
    .rx_data_i    (ser_rx_data_i),
    .word_valid_o (rx_word_valid_o),
    .word_o       (rx_word_o)
  );
endmodule

// File: rtl/tdm_stream_chk.sv
module tdm_stream_chk
  import tdm_stream_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned PORT_W   = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  src_pop_o,
  input logic [2*SAMPLE_W-1:0] src_data_i,
  input logic                  ser_tx_we_o,
  input logic [PORT_W-1:0]     ser_tx_data_o,
  input logic                  ser_rx_valid_i,
  input logic                  rx_word_valid_o,
  input logic                  underrun_o,
  input seq_state_e            seq_state
);
  assert_pop_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_pop_o |=> ser_tx_we_o && ser_tx_data_o == PORT_W'($past(src_data_i[SAMPLE_W-1:0])));

  assert_pad_no_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state != ST_RUN) |-> !src_pop_o);

  assert_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(seq_state == ST_DROP) |-> !rx_word_valid_o);

  assert_pack_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_word_valid_o |-> $past(ser_rx_valid_i));

  assert_urun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o && !start_i |=> underrun_o);

  assert_urun_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> ser_tx_we_o && ser_tx_data_o == '0);

  assert_start_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !underrun_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == ST_IDLE) |-> !src_pop_o && !ser_tx_we_o && !rx_word_valid_o);
endmodule

bind tdm_audio_streamer tdm_stream_chk #(.SAMPLE_W(SAMPLE_W), .PORT_W(PORT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .src_pop_o       (src_pop_o),
  .src_data_i      (src_data_i),
  .ser_tx_we_o     (ser_tx_we_o),
  .ser_tx_data_o   (ser_tx_data_o),
  .ser_rx_valid_i  (ser_rx_valid_i),
  .rx_word_valid_o (rx_word_valid_o),
  .underrun_o      (underrun_o),
  .seq_state       (seq_state)
);

// File: tb/tdm_audio_streamer_bench.sv
module tdm_audio_streamer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] txw;
    logic [31:0] rx_a;
    logic [31:0] rx_b;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{txw: 32'h2222_1111, rx_a: 32'hFFFF_0001, rx_b: 32'h0000_0002},
    '{txw: 32'h8000_7FFF, rx_a: 32'h1234_ABCD, rx_b: 32'h5678_EF01},
    '{txw: 32'hFFFF_0000, rx_a: 32'h0000_FFFF, rx_b: 32'hAAAA_0000},
    '{txw: 32'h0000_FFFF, rx_a: 32'h0001_8000, rx_b: 32'h7FFF_7FFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, buf_start_i = 1'b0;
  logic        src_valid_i = 1'b0;
  logic [31:0] src_data_i = '0;
  logic        src_pop_o;
  logic        ser_tx_ready_i = 1'b0;
  logic        ser_tx_we_o;
  logic [31:0] ser_tx_data_o;
  logic        ser_rx_valid_i = 1'b0;
  logic [31:0] ser_rx_data_i = '0;
  logic        rx_word_valid_o;
  logic [31:0] rx_word_o;
  logic        underrun_o;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tdm_audio_streamer u_tdm_audio_streamer (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // one transmit slot request; pop checked in-cycle, port word after the edge
  task automatic tx_slot(input string req, input logic vld, input logic [31:0] w, input logic rs,
                         input logic exp_pop, input logic [31:0] exp_data);
    ser_tx_ready_i = 1'b1; src_valid_i = vld; src_data_i = w; buf_start_i = rs;
    #1;
    check({req, " pop"}, 32'(src_pop_o), 32'(exp_pop));
    tick();
    ser_tx_ready_i = 1'b0; src_valid_i = 1'b0; buf_start_i = 1'b0;
    check({req, " we"}, 32'(ser_tx_we_o), 32'd1);
    check({req, " data"}, ser_tx_data_o, exp_data);
  endtask

  task automatic rx_beat(input string req, input logic [31:0] d, input logic rs,
                         input logic exp_v, input logic [31:0] exp_w);
    ser_rx_valid_i = 1'b1; ser_rx_data_i = d; buf_start_i = rs;
    tick();
    ser_rx_valid_i = 1'b0; buf_start_i = 1'b0;
    check({req, " valid"}, 32'(rx_word_valid_o), 32'(exp_v));
    if (exp_v) check({req, " word"}, rx_word_o, exp_w);
  endtask

  task automatic do_start(input string req);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check({req, " urun clr"}, 32'(underrun_o), 32'd0);
    tick();
    check({req, " prime we"}, 32'(ser_tx_we_o), 32'd1);
    check({req, " prime data"}, ser_tx_data_o, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check("R1 we in reset", 32'(ser_tx_we_o), 32'd0);
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    check("R1 we", 32'(ser_tx_we_o), 32'd0);
    check("R1 valid", 32'(rx_word_valid_o), 32'd0);
    check("R1 urun", 32'(underrun_o), 32'd0);

    // R12: idle ignores port events
    ser_tx_ready_i = 1'b1; src_valid_i = 1'b1; src_data_i = 32'hCAFE_F00D; ser_rx_valid_i = 1'b1;
    #1 check("R12 pop", 32'(src_pop_o), 32'd0);
    tick();
    ser_tx_ready_i = 1'b0; src_valid_i = 1'b0; ser_rx_valid_i = 1'b0;
    check("R12 we", 32'(ser_tx_we_o), 32'd0);
    check("R12 valid", 32'(rx_word_valid_o), 32'd0);

    do_start("R2");
    tick();
    check("R2 single prime", 32'(ser_tx_we_o), 32'd0);
    tx_slot("R3 pad", 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'd0);
    rx_beat("R4 drop", 32'h0000_1234, 1'b0, 1'b0, 32'd0);

    for (int i = 0; i < 4; i++) begin
      tx_slot("R5 even", 1'b1, VEC[i].txw, 1'b0, 1'b1, {16'd0, VEC[i].txw[15:0]});
      tx_slot("R6 odd", 1'b1, 32'h5A5A_5A5A, 1'b0, 1'b0, {16'd0, VEC[i].txw[31:16]});
      rx_beat("R7 even", VEC[i].rx_a, 1'b0, 1'b0, 32'd0);
      rx_beat("R8 odd", VEC[i].rx_b, 1'b0, 1'b1, {VEC[i].rx_b[15:0], VEC[i].rx_a[15:0]});
    end

    // R9: starved slot
    tx_slot("R9 zero", 1'b0, 32'h1111_1111, 1'b0, 1'b0, 32'd0);
    check("R9 flag", 32'(underrun_o), 32'd1);
    tx_slot("R9 phase low", 1'b1, 32'hAAAA_5555, 1'b0, 1'b1, 32'h0000_5555);
    tx_slot("R9 high", 1'b1, 32'h0, 1'b0, 1'b0, 32'h0000_AAAA);
    check("R9 sticky", 32'(underrun_o), 32'd1);

    // R10: realign mid-pair
    tx_slot("R10 setup", 1'b1, 32'h1357_2468, 1'b0, 1'b1, 32'h0000_2468);
    tx_slot("R10 tx realign", 1'b1, 32'h0BAD_F00D, 1'b1, 1'b1, 32'h0000_F00D);
    tx_slot("R10 tx high", 1'b1, 32'h0, 1'b0, 1'b0, 32'h0000_0BAD);
    rx_beat("R10 rx half", 32'h0000_0011, 1'b0, 1'b0, 32'd0);
    rx_beat("R10 rx realign", 32'h0000_0022, 1'b1, 1'b0, 32'd0);
    rx_beat("R10 rx pair", 32'h0000_0033, 1'b0, 1'b1, 32'h0033_0022);

    // R11: restart clears flag and reprimes
    do_start("R11");
    tx_slot("R11 pad", 1'b1, 32'h7777_6666, 1'b0, 1'b0, 32'd0);
    rx_beat("R11 drop", 32'h0000_4444, 1'b0, 1'b0, 32'd0);
    tx_slot("R11 stream", 1'b1, 32'h9999_8888, 1'b0, 1'b1, 32'h0000_8888);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule